// File: doc/BRIEF.md
# Dual-Reload PWM Timer with Interval Interrupt

This block is a tick-driven timer that produces a complementary pair of PWM outputs and a periodic interrupt. A main down-counter loads a high-phase count first. When that count reaches zero it loads a low-phase count, and it keeps alternating between the two. The positive output is high during the high phase and low during the low phase. The negative output is its inverse. In clock mode the positive output toggles on every tick during the high phase, which gives a half-rate clock in place of a steady high.

A second down-counter measures a longer interval and stops at zero. The interrupt fires only when a low phase ends while that interval counter is already at zero. At that moment the interval counter reloads and the main counter starts a new high phase. The interval counter can run on every tick or on every tenth tick.

All timing is derived from single-cycle tick-enable inputs, so the block never switches clocks. A slow tick or a divided fast tick drives the counting. A small register port sets the controls and the reload values, and it reads back both counters and a sticky interrupt flag.

Top module: `pwm_pair_timer`

## Requirements
- R1: After enable the main counter loads the high count (address 1). It decrements once per tick, and on zero it loads the low count (address 2), then the high count again, and so on. A high phase therefore lasts high+1 ticks and a low phase low+1 ticks.
- R2: While enabled, `pwm_p_o` is high during the high phase and low during the low phase, and `pwm_n_o` is always its inverse.
- R3: The interval counter decrements once per interval tick from its reload value (address 3). Once it reaches zero it stays at zero until the next interrupt.
- R4: The interrupt fires on the tick that ends a low phase while the interval counter reads zero. At that tick the interval counter reloads and the main counter loads the high count. With L = high+low+2 ticks and K interval ticks needed, the interrupt period is ceil((K+1)/L)*L ticks.
- R5: Control bit 5 at 0 makes the interval counter advance once every 10 ticks, with its prescaler restarting at each interrupt. At 1 it advances on every tick.
- R6: Control bit 0 is the enable. At 0, both counters read 0 and both outputs are low one cycle later. Setting it again loads the high count and the interval reload value.
- R7: Control bit 2 selects the tick source: 0 = `slow_tick`, 1 = `fast_tick` divided by 2^d, where d is control bits 4:3.
- R8: Control bit 1 freezes the block. While it is set, the counters, the phase and the outputs hold their values.
- R9: Control bit 6 at 1 selects clock mode. The positive output starts each high phase at 1 and inverts on every tick within that phase. At 0 it holds a steady 1 during the high phase.
- R10: The interrupt is a one-cycle pulse on `irq_o`. It also sets a sticky flag read at address 4 bit 0, which is cleared by writing 1 to that bit. Writing 0 leaves it set.
- R11: A reload value written while the timer runs does not change the count in progress. It is used at the next load of that counter.
- R12: Register map: 0 control (bits 6:0), 1 high count, 2 low count, 3 interval reload, 4 status, 5 main counter (read only), 6 interval counter (read only). All registers read back. After reset everything reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | Slow tick enable pulse |
| fast_tick | input | 1 | Fast tick enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| pwm_p_o | output | 1 | Positive PWM output |
| pwm_n_o | output | 1 | Inverted PWM output |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with its default parameters: 16-bit counters, a 2-bit fast divider field and a divide-by-ten interval prescaler. It keeps the reload values small, so that many complete interrupt intervals fit in a short run and each of the four fast divider ratios, the slow source and the divide-by-ten option can be reached. The interval between two interrupts and the number of high cycles within it are compared with closed-form values computed from the reload values. This covers the saturating zero case, the case where several periods elapse before the interrupt, and the single-tick phases that come from zero reloads.

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer #(
  parameter int CW     = 16,
  parameter int DIVW   = 2,
  parameter int ON_PRE = 10,
  parameter int AW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slow_tick,
  input  logic          fast_tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data,
  output logic          pwm_p_o,
  output logic          pwm_n_o,
  output logic          irq_o
);
  localparam int CTW  = 5 + DIVW;
  localparam int PCW  = (1 << DIVW) - 1;
  localparam int PREW = $clog2(ON_PRE);

  logic [CTW-1:0]  ctrl_q;
  logic [CW-1:0]   m_q, n_q, on_rel_q, cnt_q, on_q;
  logic            low_q, tog_q, armed_q, flag_q, irq_q;
  logic [PCW-1:0]  fcnt_q;
  logic [PREW-1:0] pre_q;

  wire            run      = ctrl_q[0];
  wire            frz      = ctrl_q[1];
  wire            src_fast = ctrl_q[2];
  wire [DIVW-1:0] fdiv     = ctrl_q[3 +: DIVW];
  wire            on_div_n = ctrl_q[3 + DIVW];
  wire            clk_mode = ctrl_q[4 + DIVW];

  wire           active   = run & armed_q & ~frz;
  wire [PCW-1:0] fmask    = PCW'((1 << fdiv) - 1);
  wire           fast_hit = fast_tick & ((fcnt_q & fmask) == fmask);
  wire           tick     = active & (src_fast ? fast_hit : slow_tick);
  wire           pre_end  = (pre_q == PREW'(ON_PRE - 1));
  wire           on_tick  = tick & (on_div_n | pre_end);
  wire           fire     = tick & low_q & (cnt_q == '0) & (on_q == '0);
  wire           hi_level = ~low_q & (~clk_mode | tog_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      m_q      <= '0;
      n_q      <= '0;
      on_rel_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        AW'(0): ctrl_q   <= wr_data[CTW-1:0];
        AW'(1): m_q      <= wr_data;
        AW'(2): n_q      <= wr_data;
        AW'(3): on_rel_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= fire;
      if (fire)
        flag_q <= 1'b1;
      else if (wr_en && wr_addr == AW'(4) && wr_data[0])
        flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      on_q    <= '0;
      low_q   <= 1'b0;
      tog_q   <= 1'b0;
      fcnt_q  <= '0;
      pre_q   <= '0;
    end else if (!run) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      on_q    <= '0;
      low_q   <= 1'b0;
      tog_q   <= 1'b0;
      fcnt_q  <= '0;
      pre_q   <= '0;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      cnt_q   <= m_q;
      on_q    <= on_rel_q;
      low_q   <= 1'b0;
      tog_q   <= 1'b1;
      fcnt_q  <= '0;
      pre_q   <= '0;
    end else begin
      if (active && fast_tick)
        fcnt_q <= fcnt_q + 1'b1;
      if (tick) begin
        if (cnt_q == '0) begin
          if (low_q) begin
            cnt_q <= m_q;
            low_q <= 1'b0;
            tog_q <= 1'b1;
          end else begin
            cnt_q <= n_q;
            low_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
          tog_q <= ~tog_q;
        end
        if (fire) begin
          on_q  <= on_rel_q;
          pre_q <= '0;
        end else begin
          if (on_tick && on_q != '0)
            on_q <= on_q - 1'b1;
          if (!on_div_n)
            pre_q <= pre_end ? '0 : pre_q + 1'b1;
        end
      end
    end
  end

  assign pwm_p_o = run & armed_q & hi_level;
  assign pwm_n_o = run & armed_q & ~hi_level;
  assign irq_o   = irq_q;

  always_comb begin
    case (rd_addr)
      AW'(0):  rd_data = CW'(ctrl_q);
      AW'(1):  rd_data = m_q;
      AW'(2):  rd_data = n_q;
      AW'(3):  rd_data = on_rel_q;
      AW'(4):  rd_data = CW'(flag_q);
      AW'(5):  rd_data = cnt_q;
      AW'(6):  rd_data = on_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pwm_pair_timer_chk.sv
module pwm_pair_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          frz,
  input logic          armed,
  input logic          low,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] on_cnt,
  input logic          irq,
  input logic          flag,
  input logic          pwm_p,
  input logic          pwm_n
);
  AST_IRQ_AT_LOW_END: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(low) && !low && $past(on_cnt) == '0)); // R4

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R10

  AST_FLAG_ON_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag); // R10

  AST_ON_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && armed && on_cnt == '0) |=> (on_cnt == '0 || irq)); // R3

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0 && on_cnt == '0 && !pwm_p && !pwm_n)); // R6

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && frz && armed) |=> (!run || ($stable(cnt) && $stable(on_cnt) && $stable(pwm_p)))); // R8

  AST_PAIR_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (!pwm_p && !pwm_n)); // R2
endmodule

bind pwm_pair_timer pwm_pair_timer_chk #(.CW(CW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .run    (ctrl_q[0]),
  .frz    (ctrl_q[1]),
  .armed  (armed_q),
  .low    (low_q),
  .cnt    (cnt_q),
  .on_cnt (on_q),
  .irq    (irq_q),
  .flag   (flag_q),
  .pwm_p  (pwm_p_o),
  .pwm_n  (pwm_n_o)
);

// File: tb/test_pwm_pair_timer.sv
module test_pwm_pair_timer;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 30000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick = 1'b0;
  logic        fast_tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        pwm_p_o, pwm_n_o, irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  pwm_pair_timer i_pwm_pair_timer (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_p_o(pwm_p_o), .pwm_n_o(pwm_n_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k = (k == 2) ? 0 : k + 1;
      slow_tick = (k == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    rd_addr = 3'(a);
    #1 d = int'(rd_data);
  endtask

  function automatic int ctrl_word(int src, int fdiv, int div10, int mode, int frz);
    return (mode << 6) | ((div10 ? 0 : 1) << 5) | (fdiv << 3) | (src << 2) | (frz << 1) | 1;
  endfunction

  function automatic int tick_cycles(int src, int fdiv);
    return src ? (1 << fdiv) : 3;
  endfunction

  function automatic int periods(int m, int n, int k, int div10);
    int l = m + n + 2;
    int ke = div10 ? 10 * k : k;
    return (ke + l) / l;
  endfunction

  function automatic int exp_interval(int m, int n, int k, int div10, int src, int fdiv);
    return periods(m, n, k, div10) * (m + n + 2) * tick_cycles(src, fdiv);
  endfunction

  function automatic int exp_ones(int m, int n, int k, int div10, int src, int fdiv, int mode);
    int hi = mode ? (m + 2) / 2 : m + 1;
    return periods(m, n, k, div10) * hi * tick_cycles(src, fdiv);
  endfunction

  task automatic measure(output int cyc, output int ones, output int mism);
    int to = 0;
    while (!irq_o && to < LIMIT) begin @(negedge clk); to++; end
    @(negedge clk);
    to = 0;
    while (!irq_o && to < LIMIT) begin @(negedge clk); to++; end
    cyc = 0; ones = 0; mism = 0;
    do begin
      ones += int'(pwm_p_o);
      if (pwm_p_o == pwm_n_o) mism++;
      cyc++;
      @(negedge clk);
    end while (!irq_o && cyc < LIMIT);
  endtask

  task automatic run_case(input int src, input int fdiv, input int div10, input int mode,
                          input int m, input int n, input int k, input string tag);
    int cyc, ones, mism, ei, eo;
    wr(0, 0);
    wr(1, m); wr(2, n); wr(3, k);
    wr(0, ctrl_word(src, fdiv, div10, mode, 0));
    measure(cyc, ones, mism);
    ei = exp_interval(m, n, k, div10, src, fdiv);
    eo = exp_ones(m, n, k, div10, src, fdiv, mode);
    check(cyc == ei, {tag, " R4 R5 R7 irq interval"}, cyc, ei);
    check(ones == eo, {tag, mode ? " R9 clock-mode high cycles" : " R1 high cycles"}, ones, eo);
    check(mism == 0, {tag, " R2 outputs complementary"}, mism, 0);
  endtask

  initial begin
    int v, cyc, ones, mism;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(0, v); check(v == 0, "R12 reset control", v, 0);
    rd(5, v); check(v == 0, "R12 reset main counter", v, 0);
    rd(6, v); check(v == 0, "R12 reset interval counter", v, 0);
    check(!pwm_p_o && !pwm_n_o && !irq_o, "R6 reset outputs low", int'(pwm_p_o | pwm_n_o | irq_o), 0);

    wr(1, 5); wr(2, 3); wr(3, 7);
    wr(0, ctrl_word(1, 0, 0, 0, 1));
    repeat (2) @(negedge clk);
    rd(5, v); check(v == 5, "R1 start loads high count", v, 5);
    rd(6, v); check(v == 7, "R6 start loads interval reload", v, 7);
    check(pwm_p_o && !pwm_n_o, "R2 high phase outputs", int'(pwm_p_o), 1);
    repeat (20) @(negedge clk);
    rd(5, v); check(v == 5, "R8 freeze holds main counter", v, 5);
    rd(6, v); check(v == 7, "R8 freeze holds interval counter", v, 7);
    wr(1, 9);
    rd(5, v); check(v == 5, "R11 reload write leaves count", v, 5);
    rd(1, v); check(v == 9, "R12 high count readback", v, 9);

    wr(0, ctrl_word(1, 0, 0, 0, 0));
    measure(cyc, ones, mism);
    check(cyc == 14, "R11 new high count used", cyc, 14);
    check(ones == 10, "R11 new high phase length", ones, 10);
    check(irq_o, "R10 irq pulse seen", int'(irq_o), 1);
    @(negedge clk);
    check(!irq_o, "R10 irq single cycle", int'(irq_o), 0);

    wr(0, ctrl_word(1, 0, 0, 0, 1));
    rd(4, v); check(v == 1, "R10 sticky flag set", v, 1);
    wr(4, 0);
    rd(4, v); check(v == 1, "R10 write 0 keeps flag", v, 1);
    wr(4, 1);
    rd(4, v); check(v == 0, "R10 write 1 clears flag", v, 0);

    wr(0, 0);
    repeat (2) @(negedge clk);
    rd(5, v); check(v == 0, "R6 disable clears main counter", v, 0);
    rd(6, v); check(v == 0, "R6 disable clears interval counter", v, 0);
    check(!pwm_p_o && !pwm_n_o, "R6 disable drives outputs low", int'(pwm_p_o | pwm_n_o), 0);

    wr(1, 20); wr(2, 20); wr(3, 3);
    wr(0, ctrl_word(1, 0, 0, 0, 0));
    repeat (30) @(negedge clk);
    rd(6, v); check(v == 0, "R3 interval counter saturates at zero", v, 0);
    check(!irq_o, "R4 no irq before low phase ends", int'(irq_o), 0);

    run_case(1, 0, 0, 0, 0, 0, 0, "corner zero reloads");
    run_case(1, 0, 0, 0, 0, 0, 2, "corner R3 several periods");
    run_case(1, 0, 1, 0, 0, 0, 2, "corner R5 divide by ten");
    run_case(1, 3, 0, 1, 0, 2, 1, "corner R9 clock mode zero high");
    run_case(0, 2, 0, 0, 2, 1, 4, "corner R7 slow source");

    for (int i = 0; i < 10; i++) begin
      int src = int'($urandom_range(1, 0));
      int fdiv = int'($urandom_range(3, 0));
      int d10 = int'($urandom_range(1, 0));
      int mode = int'($urandom_range(1, 0));
      int m = int'($urandom_range(15, 0));
      int n = int'($urandom_range(15, 0));
      int k = int'($urandom_range(40, 0));
      run_case(src, fdiv, d10, mode, m, n, k, "random");
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule